// File: doc/BRIEF.md
# Green-Mode PWM Timing Generator

This block produces the gate pulse train for a peak-current-mode flyback controller and runs on a system clock. It reads a digitized feedback level, a current-limit comparator flag and an enable from the fault supervisor. It drives the gate, a blanking indicator, a one-clock cycle-start strobe and the peak-current target code. A DAC and an external comparator turn that target code into the current-limit flag. The analog comparator, the slope ramp, the gate driver and the feedback converter are outside the block.

At high feedback the block switches at a fixed nominal frequency. As feedback falls through a green-mode band, the period grows linearly until it reaches a floor frequency, and it never goes below that floor. Below a zero-duty threshold the block stops switching altogether, which produces burst operation. It starts again on the first clock after feedback comes back above that threshold. Each pulse begins with a leading-edge blanking window, and the on-time is capped at a fixed share of the period. After each enable, a soft-start ramp limits the peak-current target.

Top module: `green_pwm_timer`

## Requirements
- R1: While reset is high, `gate`, `blank` and `cyc_start` are all 0.
- R2: When `fb_code >= FB_GREEN`, the period is `CLK_HZ/65000` clocks, or `CLK_HZ/100000` clocks when `FAST_VARIANT=1`. The period is measured between consecutive `cyc_start` pulses.
- R3: When `FB_FLOOR < fb_code < FB_GREEN`, the period is `P_FLOOR - (fb_code-FB_FLOOR)*(P_FLOOR-P_NOM)/(FB_GREEN-FB_FLOOR)`, using integer division. When `fb_code <= FB_FLOOR`, the period is `P_FLOOR = CLK_HZ/F_FLOOR_HZ`, and it is never longer.
- R4: When `fb_code < FB_ZDC`, the block issues no new cycle: there is no `cyc_start` and `gate` stays low after the running cycle ends. From idle, the clock edge after `fb_code` returns to `FB_ZDC` or above raises `gate` and `cyc_start` together.
- R5: `blank` is high for exactly `LEB_CYC = (CLK_HZ/1e6)*LEB_NS/1000` clocks from turn-on. An `ilim` that is high during those clocks does not end the pulse. With `ilim` held high from turn-on, `gate` stays high for `LEB_CYC+1` clocks.
- R6: When `ilim` is high in a clock where `gate` is high and `blank` is low, `gate` goes low on the next clock edge.
- R7: `ipk_limit` is loaded at each cycle start with the smaller of `(fb_code-FB_OFFSET)>>2` (0 when `fb_code <= FB_OFFSET`) and the soft-start limit. A cycle never starts while that value is 0.
- R8: The soft-start limit is `n*TGT_MAX/SS_CYC`, where `n` is the number of clocks since enable, saturating at `SS_CYC = SS_US*CLK_HZ/1e6`, and `TGT_MAX = (2^FB_W-1-FB_OFFSET)>>2`. The limit never decreases while enabled. The first pulse after enable carries `ipk_limit = 1`.
- R9: The gate on-time never exceeds `period*MAX_DUTY_PCT/100` clocks. That is the on-time when `ilim` stays low.
- R10: The period and on-time cap are latched at cycle start. A change of `fb_code` during a cycle leaves that cycle's length unchanged.
- R11: On the clock edge after `en` goes low, `gate` falls and switching stops. The soft-start ramp restarts from 0 at the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable from the fault supervisor |
| fb_code | input | FB_W | Digitized feedback level |
| ilim | input | 1 | Current-limit comparator flag |
| gate | output | 1 | Registered gate drive |
| blank | output | 1 | Leading-edge blanking window active |
| cyc_start | output | 1 | One-clock strobe at each turn-on |
| ipk_limit | output | FB_W | Peak-current target for the current pulse |

## Verification
The main instance keeps the default 50 MHz timing, which gives a 769-clock nominal period, a 2777-clock floor and a 17-clock blanking window. Its soft-start is shortened to 20 us (1000 clocks), so the ramp's first step and its completion both fall inside a short run and the run can re-enable to exercise the ramp again. A second instance built with `FAST_VARIANT=1` exposes the 500-clock period. The feedback thresholds 160/80/40 with offset 30 place the nominal, linear, floor and burst regions within one sweep of feedback codes.

// File: rtl/green_pwm_pkg.sv
package green_pwm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_OFF  = 2'd2
  } cyc_state_t;

endpackage

// File: rtl/gpw_period_map.sv
module gpw_period_map #(
  parameter int FB_W         = 8,
  parameter int PER_W        = 12,
  parameter int P_NOM        = 769,
  parameter int P_FLOOR      = 2777,
  parameter int FB_GREEN     = 160,
  parameter int FB_FLOOR     = 80,
  parameter int MAX_DUTY_PCT = 75
) (
  input  logic [FB_W-1:0]  fb,
  output logic [PER_W-1:0] period,
  output logic [PER_W-1:0] ton_max
);
  localparam int unsigned NOM_U   = P_NOM;
  localparam int unsigned FLOOR_U = P_FLOOR;
  localparam int unsigned SPAN_P  = P_FLOOR - P_NOM;
  localparam int unsigned SPAN_FB = FB_GREEN - FB_FLOOR;
  localparam int unsigned GRN_U   = FB_GREEN;
  localparam int unsigned FLR_U   = FB_FLOOR;
  localparam int unsigned DUTY_U  = MAX_DUTY_PCT;

  int unsigned fbi;
  int unsigned p;
  int unsigned t;

  // Piecewise-linear map: flat at nominal, linear stretch, flat at floor
  always_comb begin
    fbi = 32'(fb);
    if (fbi >= GRN_U)
      p = NOM_U;
    else if (fbi <= FLR_U)
      p = FLOOR_U;
    else
      p = FLOOR_U - ((fbi - FLR_U) * SPAN_P) / SPAN_FB;
    t       = (p * DUTY_U) / 100;
    period  = PER_W'(p);
    ton_max = PER_W'(t);
  end

endmodule

// File: rtl/gpw_peak_limit.sv
module gpw_peak_limit #(
  parameter int FB_W      = 8,
  parameter int FB_OFFSET = 30,
  parameter int SS_CYC    = 1000,
  parameter int SS_W      = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [FB_W-1:0] fb,
  output logic [FB_W-1:0] tgt_eff
);
  localparam int unsigned TGT_MAX = ((2 ** FB_W - 1) - FB_OFFSET) >> 2;
  localparam int unsigned OFS_U   = FB_OFFSET;
  localparam int unsigned SSC_U   = SS_CYC;

  logic [SS_W-1:0] ss_cnt;
  logic [FB_W-1:0] lim_q;
  logic [FB_W-1:0] tgt_fb;
  int unsigned     fbi;

  // Soft-start ramp counter, cleared while disabled
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ss_cnt <= '0;
      lim_q  <= '0;
    end else begin
      if (32'(ss_cnt) != SSC_U) ss_cnt <= ss_cnt + SS_W'(1);
      lim_q <= FB_W'((32'(ss_cnt) * TGT_MAX) / SSC_U);
    end
  end

  // Feedback-derived target and the soft-start clamp
  always_comb begin
    fbi = 32'(fb);
    if (fbi > OFS_U) tgt_fb = FB_W'((fbi - OFS_U) >> 2);
    else             tgt_fb = '0;
    tgt_eff = (tgt_fb < lim_q) ? tgt_fb : lim_q;
  end

  p_ss_monotone_r8: assert property (@(posedge clk) disable iff (rst)
    en |=> (!en || lim_q >= $past(lim_q)));

  p_ss_off_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (lim_q == '0));

endmodule

// File: rtl/gpw_cycle_fsm.sv
module gpw_cycle_fsm
  import green_pwm_pkg::*;
#(
  parameter int FB_W    = 8,
  parameter int PER_W   = 12,
  parameter int LEB_CYC = 17,
  parameter int LEB_W   = 5,
  parameter int FB_ZDC  = 40,
  parameter int P_NOM   = 769,
  parameter int P_FLOOR = 2777
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [FB_W-1:0]  fb,
  input  logic             ilim,
  input  logic [PER_W-1:0] per_in,
  input  logic [PER_W-1:0] ton_in,
  input  logic [FB_W-1:0]  tgt_in,
  output logic             gate,
  output logic             blank,
  output logic             strobe,
  output logic [FB_W-1:0]  ipk
);
  localparam int unsigned ZDC_U = FB_ZDC;

  cyc_state_t       state;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] ton_q;
  logic [LEB_W-1:0] leb_left;
  logic             gate_q;
  logic             blank_q;
  logic             strobe_q;
  logic [FB_W-1:0]  ipk_q;
  logic             at_end;
  logic             start_ok;
  logic             on_done;

  assign at_end   = (state == ST_IDLE) || (cnt == period_q - PER_W'(1));
  assign start_ok = (32'(fb) >= ZDC_U) && (tgt_in != '0);
  assign on_done  = ((cnt + PER_W'(1)) >= ton_q) || (!blank_q && ilim);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      period_q <= '0;
      ton_q    <= '0;
      leb_left <= '0;
      gate_q   <= 1'b0;
      blank_q  <= 1'b0;
      strobe_q <= 1'b0;
      ipk_q    <= '0;
    end else begin
      strobe_q <= 1'b0;
      if (at_end) begin
        cnt <= '0;
        if (start_ok) begin
          state    <= ST_ON;
          period_q <= per_in;
          ton_q    <= ton_in;
          ipk_q    <= tgt_in;
          gate_q   <= 1'b1;
          blank_q  <= 1'b1;
          leb_left <= LEB_W'(LEB_CYC - 1);
          strobe_q <= 1'b1;
        end else begin
          state   <= ST_IDLE;
          gate_q  <= 1'b0;
          blank_q <= 1'b0;
        end
      end else begin
        cnt <= cnt + PER_W'(1);
        if (state == ST_ON) begin
          if (on_done) begin
            state   <= ST_OFF;
            gate_q  <= 1'b0;
            blank_q <= 1'b0;
          end else if (leb_left != '0) begin
            leb_left <= leb_left - LEB_W'(1);
          end else begin
            blank_q <= 1'b0;
          end
        end
      end
    end
  end

  assign gate   = gate_q;
  assign blank  = blank_q;
  assign strobe = strobe_q;
  assign ipk    = ipk_q;

  p_strobe_turn_on_r4: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> (gate_q && cnt == '0));

  p_blank_in_on_r5: assert property (@(posedge clk) disable iff (rst)
    blank_q |-> gate_q);

  p_duty_cap_r9: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> (cnt < ton_q));

  p_period_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (en && state != ST_IDLE && !at_end) |=> $stable(period_q));

  p_period_range_r3: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (32'(period_q) >= 32'(P_NOM) && 32'(period_q) <= 32'(P_FLOOR)));

  p_no_zero_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> (ipk_q != '0));

  p_gate_off_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!gate_q && !strobe_q));

endmodule

// File: rtl/green_pwm_timer.sv
module green_pwm_timer #(
  parameter int CLK_HZ       = 50_000_000,
  parameter bit FAST_VARIANT = 1'b0,
  parameter int F_FLOOR_HZ   = 18_000,
  parameter int LEB_NS       = 350,
  parameter int SS_US        = 5000,
  parameter int MAX_DUTY_PCT = 75,
  parameter int FB_W         = 8,
  parameter int FB_GREEN     = 160,
  parameter int FB_FLOOR     = 80,
  parameter int FB_ZDC       = 40,
  parameter int FB_OFFSET    = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [FB_W-1:0] fb_code,
  input  logic            ilim,
  output logic            gate,
  output logic            blank,
  output logic            cyc_start,
  output logic [FB_W-1:0] ipk_limit
);
  localparam int F_NOM_HZ = FAST_VARIANT ? 100_000 : 65_000;
  localparam int P_NOM    = CLK_HZ / F_NOM_HZ;
  localparam int P_FLOOR  = CLK_HZ / F_FLOOR_HZ;
  localparam int PER_W    = $clog2(P_FLOOR + 1);
  localparam int LEB_RAW  = (CLK_HZ / 1_000_000) * LEB_NS / 1000;
  localparam int LEB_CYC  = (LEB_RAW < 1) ? 1 : LEB_RAW;
  localparam int LEB_W    = $clog2(LEB_CYC + 1);
  localparam int SS_RAW   = SS_US * (CLK_HZ / 1_000_000);
  localparam int SS_CYC   = (SS_RAW < 1) ? 1 : SS_RAW;
  localparam int SS_W     = $clog2(SS_CYC + 1);

  logic [PER_W-1:0] per_w;
  logic [PER_W-1:0] ton_w;
  logic [FB_W-1:0]  tgt_w;

  gpw_period_map #(
    .FB_W(FB_W), .PER_W(PER_W), .P_NOM(P_NOM), .P_FLOOR(P_FLOOR),
    .FB_GREEN(FB_GREEN), .FB_FLOOR(FB_FLOOR), .MAX_DUTY_PCT(MAX_DUTY_PCT)
  ) u_map (
    .fb(fb_code), .period(per_w), .ton_max(ton_w)
  );

  gpw_peak_limit #(
    .FB_W(FB_W), .FB_OFFSET(FB_OFFSET), .SS_CYC(SS_CYC), .SS_W(SS_W)
  ) u_peak (
    .clk(clk), .rst(rst), .en(en), .fb(fb_code), .tgt_eff(tgt_w)
  );

  gpw_cycle_fsm #(
    .FB_W(FB_W), .PER_W(PER_W), .LEB_CYC(LEB_CYC), .LEB_W(LEB_W),
    .FB_ZDC(FB_ZDC), .P_NOM(P_NOM), .P_FLOOR(P_FLOOR)
  ) u_fsm (
    .clk(clk), .rst(rst), .en(en), .fb(fb_code), .ilim(ilim),
    .per_in(per_w), .ton_in(ton_w), .tgt_in(tgt_w),
    .gate(gate), .blank(blank), .strobe(cyc_start), .ipk(ipk_limit)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!gate && !blank && !cyc_start));

endmodule

// File: tb/test_green_pwm_timer.sv
module test_green_pwm_timer;

  localparam int FB_W = 8;

  typedef struct {
    int per;
    int ton;
    int ipk;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            en = 1'b0;
  logic            en_f = 1'b0;
  logic [FB_W-1:0] fb = 8'd200;
  logic            ilim = 1'b0;
  logic            gate, blank, strobe;
  logic [FB_W-1:0] ipk;
  logic            gate_f, blank_f, strobe_f;
  logic [FB_W-1:0] ipk_f;

  int n_chk = 0;
  int n_fail = 0;
  exp_t q[$];
  exp_t cur;
  bit   active = 1'b0;
  int   per_cnt = 0;
  int   hi_cnt = 0;
  int   last_per = 0;
  int   done_cnt = 0;

  always #10 clk = ~clk;

  green_pwm_timer #(.SS_US(20)) i_green_pwm_timer (
    .clk(clk), .rst(rst), .en(en), .fb_code(fb), .ilim(ilim),
    .gate(gate), .blank(blank), .cyc_start(strobe), .ipk_limit(ipk)
  );

  green_pwm_timer #(.SS_US(20), .FAST_VARIANT(1'b1)) i_green_pwm_timer_fast (
    .clk(clk), .rst(rst), .en(en_f), .fb_code(8'd200), .ilim(1'b0),
    .gate(gate_f), .blank(blank_f), .cyc_start(strobe_f), .ipk_limit(ipk_f)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic int per_of(input int f);
    if (f >= 160) return 769;
    if (f <= 80) return 2777;
    return 2777 - ((f - 80) * 2008) / 80;
  endfunction

  function automatic int tgt_of(input int f);
    return (f > 30) ? ((f - 30) >> 2) : 0;
  endfunction

  // Monitor: scoreboard compares each armed cycle at the next strobe
  always @(negedge clk) begin
    if (strobe) begin
      if (active) begin
        chk("R3/R2 period", per_cnt, cur.per);
        chk("R9 on-time", hi_cnt, cur.ton);
        done_cnt++;
      end
      last_per = per_cnt;
      if (q.size() > 0) begin
        cur = q.pop_front();
        active = 1'b1;
        chk("R7 ipk_limit", int'(ipk), cur.ipk);
      end else begin
        active = 1'b0;
      end
      per_cnt = 1;
      hi_cnt  = gate ? 1 : 0;
    end else begin
      per_cnt++;
      if (gate) hi_cnt++;
    end
  end

  task automatic wait_strobe();
    @(negedge clk);
    while (!strobe) @(negedge clk);
    #1;
  endtask

  // Driver: change feedback right after a cycle start, push expectations
  task automatic expect_cycles(input int f, input int n, input int prev_per);
    int tgt_done;
    exp_t e;
    wait_strobe();
    fb = FB_W'(f);
    e.per = per_of(f);
    e.ton = (e.per * 75) / 100;
    e.ipk = tgt_of(f);
    for (int i = 0; i < n; i++) q.push_back(e);
    tgt_done = done_cnt + n;
    wait_strobe();
    if (prev_per != 0) chk("R10 in-flight period", last_per, prev_per);
    while (done_cnt < tgt_done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt_s;
    int hi;
    int bl;
    repeat (4) @(negedge clk);
    chk("R1 gate in reset", int'(gate), 0);
    chk("R1 blank in reset", int'(blank), 0);
    chk("R1 strobe in reset", int'(strobe), 0);
    rst = 1'b0;
    en_f = 1'b1;
    cnt_s = 0;
    repeat (50) begin @(negedge clk); if (strobe || gate) cnt_s++; end
    chk("R11 idle while disabled", cnt_s, 0);

    // Soft-start: first pulse carries the smallest nonzero target
    en = 1'b1;
    wait_strobe();
    chk("R8 first ipk", int'(ipk), 1);
    repeat (1200) @(negedge clk);

    expect_cycles(200, 3, 0);
    expect_cycles(120, 3, 769);
    expect_cycles(80, 2, per_of(120));
    expect_cycles(60, 2, 2777);
    expect_cycles(159, 2, 2777);

    // Burst: below zero-duty threshold nothing starts
    wait_strobe();
    fb = 8'd30;
    repeat (3200) @(negedge clk);
    cnt_s = 0;
    repeat (3000) begin @(negedge clk); if (strobe || gate) cnt_s++; end
    chk("R4 burst no pulses", cnt_s, 0);
    fb = 8'd200;
    @(negedge clk);
    chk("R4 resume strobe", int'(strobe), 1);
    chk("R4 resume gate", int'(gate), 1);

    // Blanking: ilim held high from turn-on
    wait_strobe();
    ilim = 1'b1;
    hi = 1;
    bl = blank ? 1 : 0;
    @(negedge clk);
    while (gate) begin hi++; if (blank) bl++; @(negedge clk); end
    ilim = 1'b0;
    chk("R5 gate width with ilim", hi, 18);
    chk("R5 blank width", bl, 17);

    // Cycle-by-cycle limit after blanking
    wait_strobe();
    repeat (100) @(negedge clk);
    chk("R6 gate before limit", int'(gate), 1);
    ilim = 1'b1;
    @(negedge clk);
    chk("R6 gate after limit", int'(gate), 0);
    ilim = 1'b0;

    // Enable drop mid-pulse, then ramp restart
    wait_strobe();
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R11 gate off", int'(gate), 0);
    cnt_s = 0;
    repeat (20) begin @(negedge clk); if (strobe) cnt_s++; end
    chk("R11 no strobe", cnt_s, 0);
    en = 1'b1;
    wait_strobe();
    chk("R8 ramp restart ipk", int'(ipk), 1);

    // Fast variant period
    @(negedge clk);
    while (!strobe_f) @(negedge clk);
    cnt_s = 1;
    @(negedge clk);
    while (!strobe_f) begin cnt_s++; @(negedge clk); end
    chk("R2 fast variant period", cnt_s, 500);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule